// File: doc/BRIEF.md
# Synchronous Serial Shift Engine (SPI frame format)

This block moves parallel words across a four-wire synchronous serial link in the common SPI frame format. A word offered on a valid/ready transmit port is shifted out one bit per serial clock period, most significant bit first. At the same time the bits arriving on the data input are gathered and handed out as a right-justified parallel word with a one-cycle valid strobe. The word length, the idle level of the serial clock, the edge on which data is captured, and the role (clock and select driver, or clock and select follower) are all set by static configuration inputs. These inputs must be held steady while a frame is in flight.

In the driving role, the serial clock comes from the system clock through two cascaded counters: an even prescale value and a rate value. The bit period is the product of the prescale value and the rate value plus one. In the following role, the external clock and select are brought in through two-stage synchronisers, so the external bit rate has to stay well below the system clock. An internal loopback path ties the transmit bit straight to the receive sampler. In the following role, a separate control keeps the data output released so that several followers can share one return line.

Top module: `sspi_engine`

## Requirements
- R1: In the driving role, consecutive serial clock transitions are `max(1, presc>>1) * (rate+1)` system clocks apart, so one bit period equals prescale times (rate+1). Bit 0 of the prescale value has no effect, and a prescale below 2 acts as 2.
- R2: A frame carries `size_m1+1` bits, which gives exactly twice that many serial clock transitions in the driving role. Size field values 0 to 2 act as 3, which means 4 bits.
- R3: Outside a frame the serial clock output rests at the level of `cfg_cpol`, and every driving-role frame leaves the clock at that level.
- R4: With `cfg_cpha`=0, the first bit is on the data output before the first clock transition, and data is captured on odd-numbered transitions (1st, 3rd, ...). With `cfg_cpha`=1, data changes on odd-numbered transitions and is captured on even-numbered ones.
- R5: Bits leave and arrive most significant bit first. The received word is right-justified, with zeros above the word size, and `rx_valid` is high for exactly one cycle per frame.
- R6: With `cfg_loop`=1, the receiver takes the engine's own transmit bits, `rx_data` equals the transmitted word, and `sd_in` has no effect.
- R7: In the following role, `sd_oe` stays low for as long as `cfg_sod`=1, while reception still works. With `cfg_sod`=0, `sd_oe` is high only while the synchronised select is low.
- R8: In the driving role, `sel_n_out` is low from the cycle after the word is accepted until the frame ends, and it is high otherwise. The serial clock only moves while `sel_n_out` is low.
- R9: In the following role, the frame starts on the synchronised falling edge of `sel_n_in`, where a word offered with `tx_valid` is taken (zeros are sent if none is offered). The frame ends after `size_m1+1` capture edges of `sck_in`.
- R10: With `en`=0, the engine returns to idle within one cycle, which may cut a frame short. It keeps `tx_ready`, `busy` and `sd_oe` low and `sel_n_out` high.
- R11: `tx_ready` is high only while no frame is in progress. `busy` is high from the cycle after acceptance until the cycle in which `rx_valid` is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Engine enable |
| cfg_master | input | 1 | 1 = drive clock and select, 0 = follow external clock and select |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0 = capture on odd transitions, 1 = capture on even transitions |
| cfg_size_m1 | input | 4 | Word size minus one |
| cfg_loop | input | 1 | Internal loopback of transmit bit to receiver |
| cfg_sod | input | 1 | Keep data output released in the following role |
| cfg_presc | input | 8 | Prescale value (even, bit 0 unused) |
| cfg_rate | input | 8 | Rate value; divider multiplies by rate+1 |
| tx_data | input | 16 | Word to transmit, right-justified |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit word taken this cycle when valid |
| rx_data | output | 16 | Received word, right-justified |
| rx_valid | output | 1 | One-cycle strobe for rx_data |
| busy | output | 1 | Frame in progress |
| sck_out | output | 1 | Serial clock in the driving role |
| sel_n_out | output | 1 | Active-low select in the driving role |
| sck_in | input | 1 | External serial clock in the following role |
| sel_n_in | input | 1 | External active-low select in the following role |
| sd_in | input | 1 | Serial data input |
| sd_out | output | 1 | Serial data output |
| sd_oe | output | 1 | Output enable for sd_out (low = high impedance) |

## Verification
The driving role runs under all four polarity and phase pairings, with a bench-side follower that returns a different word. This shows whether each bit is captured on the correct transition, and whether the transmitted and received paths are kept apart. Fixed transfers exercise the word-size clamp, an odd prescale, a zero prescale and loopback with a contradicting `sd_in`; these show that the bit-0 and floor rules apply and that loopback really bypasses the pin. Seeded random transfers then vary word size, divider values and data together, with the edge spacing measured each time. The following role is driven by a slow bench clock with and without output release and loopback. A frame cut short by dropping the enable shows that the engine returns to idle.

// File: rtl/sspi_pkg.sv
package sspi_pkg;

  // Smallest supported word, stored as size minus one.
  localparam int MIN_BITS_M1 = 3;

  // Frame position flags shared by both role engines.
  typedef enum logic [1:0] {
    PH_LEAD  = 2'd0,
    PH_TRAIL = 2'd1,
    PH_NONE  = 2'd2
  } edge_kind_t;

  // Apply the floor on the size field.
  function automatic logic [3:0] clamp_size(input logic [3:0] fld);
    return (fld < 4'(MIN_BITS_M1)) ? 4'(MIN_BITS_M1) : fld;
  endfunction

endpackage

// File: rtl/sspi_clkdiv.sv
module sspi_clkdiv #(
  parameter int PW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] presc,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int HW = PW - 1;

  logic [HW-1:0] half_pre;
  logic [HW-1:0] pcnt;
  logic [RW-1:0] rcnt;

  // Prescale counts in half-bit units; bit 0 is dropped, floor of one.
  assign half_pre = (presc[PW-1:1] == '0) ? HW'(1) : presc[PW-1:1];

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      rcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pcnt == half_pre - HW'(1)) begin
        pcnt <= '0;
        if (rcnt == rate) begin
          rcnt <= '0;
          tick <= 1'b1;
        end else begin
          rcnt <= rcnt + RW'(1);
        end
      end else begin
        pcnt <= pcnt + HW'(1);
      end
    end
  end

  // R1: with a divide ratio above one, ticks are never back to back.
  p_tick_gap_r1: assert property (@(posedge clk) disable iff (rst)
    (tick && run && (half_pre != HW'(1) || rate != '0))
      |=> (!tick || !$stable(rate) || !$stable(presc) || !$stable(run)))
    else $error("tick spacing violated");

endmodule

// File: rtl/sspi_master.sv
module sspi_master #(
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [SW-1:0] nb_m1,
  input  logic          loop,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          tick,
  input  logic          sd_in,
  output logic          sck,
  output logic          sel_n,
  output logic          dout,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          busy
);
  localparam int EW = SW + 1;

  logic          busy_r, sck_r, sel_n_r, dout_r, rxv_r;
  logic [EW-1:0] ecnt;
  logic [SW-1:0] lnb;
  logic          lcpha;
  logic [DW-1:0] tsr, rsr, rsr_nx, rxd_r, al;
  logic          din, samp, last;

  assign al       = tx_data << (SW'(DW - 1) - nb_m1);
  assign din      = loop ? dout_r : sd_in;
  assign tx_ready = en && !busy_r;

  always_comb begin
    samp   = (ecnt[0] == lcpha);
    rsr_nx = samp ? {rsr[DW-2:0], din} : rsr;
    last   = (ecnt == {lnb, 1'b1});
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy_r  <= 1'b0;
      sel_n_r <= 1'b1;
      sck_r   <= cpol;
      ecnt    <= '0;
      tsr     <= '0;
      rsr     <= '0;
      dout_r  <= 1'b0;
      rxv_r   <= 1'b0;
      lnb     <= '0;
      lcpha   <= 1'b0;
      if (rst) rxd_r <= '0;
    end else begin
      rxv_r <= 1'b0;
      if (!busy_r) begin
        sck_r   <= cpol;
        sel_n_r <= 1'b1;
        if (tx_valid) begin
          busy_r  <= 1'b1;
          sel_n_r <= 1'b0;
          ecnt    <= '0;
          rsr     <= '0;
          lnb     <= nb_m1;
          lcpha   <= cpha;
          dout_r  <= al[DW-1];
          tsr     <= cpha ? al : (al << 1);
        end
      end else if (tick) begin
        sck_r <= ~sck_r;
        ecnt  <= ecnt + EW'(1);
        rsr   <= rsr_nx;
        if (!samp) begin
          dout_r <= tsr[DW-1];
          tsr    <= tsr << 1;
        end
        if (last) begin
          busy_r  <= 1'b0;
          sel_n_r <= 1'b1;
          rxv_r   <= 1'b1;
          rxd_r   <= rsr_nx;
        end
      end
    end
  end

  assign sck      = sck_r;
  assign sel_n    = sel_n_r;
  assign dout     = dout_r;
  assign rx_data  = rxd_r;
  assign rx_valid = rxv_r;
  assign busy     = busy_r;

  // R2: the transition counter never passes the frame length.
  p_edge_bound_r2: assert property (@(posedge clk) disable iff (rst)
    busy_r |-> (ecnt <= {lnb, 1'b1}))
    else $error("edge count overrun");

  // R3: a clock left idle for two cycles sits at the polarity level.
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy_r && $past(!busy_r) && $stable(cpol)) |-> (sck_r == cpol))
    else $error("clock not at idle level");

  // R8: select is held low for the whole frame.
  p_sel_frame_r8: assert property (@(posedge clk) disable iff (rst)
    busy_r |-> !sel_n_r)
    else $error("select released mid frame");

  // R5: receive strobe lasts one cycle.
  p_rxv_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rxv_r |=> !rxv_r)
    else $error("rx strobe too long");

endmodule

// File: rtl/sspi_slave.sv
module sspi_slave #(
  parameter int DW = 16,
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cpol,
  input  logic          cpha,
  input  logic [SW-1:0] nb_m1,
  input  logic          loop,
  input  logic          sod,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          sck_in,
  input  logic          sel_n_in,
  input  logic          sd_in,
  output logic          dout,
  output logic          oe,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          busy
);
  import sspi_pkg::*;

  logic [2:0]    sck_s, sel_s;
  logic          busy_r, dout_r, oe_r, rxv_r, lcpha;
  logic [SW-1:0] scnt, lnb;
  logic [DW-1:0] tsr, rsr, rsr_nx, rxd_r, al;
  logic          din, sel_fall, samp, chg;
  edge_kind_t    ek;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_s <= '0;
      sel_s <= '1;
    end else begin
      sck_s <= {sck_s[1:0], sck_in};
      sel_s <= {sel_s[1:0], sel_n_in};
    end
  end

  always_comb begin
    if (sck_s[1] == sck_s[2]) ek = PH_NONE;
    else if (sck_s[2] == cpol) ek = PH_LEAD;
    else ek = PH_TRAIL;
    samp     = lcpha ? (ek == PH_TRAIL) : (ek == PH_LEAD);
    chg      = lcpha ? (ek == PH_LEAD) : (ek == PH_TRAIL);
    sel_fall = sel_s[2] && !sel_s[1];
    din      = loop ? dout_r : sd_in;
    rsr_nx   = {rsr[DW-2:0], din};
    al       = tx_valid ? (tx_data << (SW'(DW - 1) - nb_m1)) : '0;
  end

  assign tx_ready = en && sel_fall;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy_r <= 1'b0;
      dout_r <= 1'b0;
      oe_r   <= 1'b0;
      rxv_r  <= 1'b0;
      scnt   <= '0;
      lnb    <= '0;
      lcpha  <= 1'b0;
      tsr    <= '0;
      rsr    <= '0;
      if (rst) rxd_r <= '0;
    end else begin
      rxv_r <= 1'b0;
      oe_r  <= !sod && !sel_s[1];
      if (sel_s[1]) begin
        busy_r <= 1'b0;
      end else if (sel_fall) begin
        busy_r <= 1'b1;
        scnt   <= '0;
        rsr    <= '0;
        lnb    <= nb_m1;
        lcpha  <= cpha;
        dout_r <= al[DW-1];
        tsr    <= cpha ? al : (al << 1);
      end else if (busy_r) begin
        if (samp) begin
          rsr  <= rsr_nx;
          scnt <= scnt + SW'(1);
          if (scnt == lnb) begin
            busy_r <= 1'b0;
            rxv_r  <= 1'b1;
            rxd_r  <= rsr_nx;
          end
        end
        if (chg) begin
          dout_r <= tsr[DW-1];
          tsr    <= tsr << 1;
        end
      end
    end
  end

  assign dout     = dout_r;
  assign oe       = oe_r;
  assign rx_data  = rxd_r;
  assign rx_valid = rxv_r;
  assign busy     = busy_r;

  // R7: output stays released while the disable is held.
  p_oe_sod_r7: assert property (@(posedge clk) disable iff (rst)
    (sod && $past(sod)) |-> !oe_r)
    else $error("output driven while disabled");

  // R5: receive strobe lasts one cycle.
  p_srxv_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    rxv_r |=> !rxv_r)
    else $error("rx strobe too long");

endmodule

// File: rtl/sspi_engine.sv
module sspi_engine #(
  parameter int DW = 16,
  parameter int PW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cfg_master,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic [3:0]    cfg_size_m1,
  input  logic          cfg_loop,
  input  logic          cfg_sod,
  input  logic [PW-1:0] cfg_presc,
  input  logic [RW-1:0] cfg_rate,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          busy,
  output logic          sck_out,
  output logic          sel_n_out,
  input  logic          sck_in,
  input  logic          sel_n_in,
  input  logic          sd_in,
  output logic          sd_out,
  output logic          sd_oe
);
  import sspi_pkg::*;

  localparam int SW = $clog2(DW);

  logic          m_en, s_en, tick;
  logic [SW-1:0] nb_m1;
  logic          m_ready, m_dout, m_rxv, m_busy;
  logic          s_ready, s_dout, s_oe, s_rxv, s_busy;
  logic [DW-1:0] m_rxd, s_rxd;

  assign m_en  = en && cfg_master;
  assign s_en  = en && !cfg_master;
  assign nb_m1 = SW'(clamp_size(cfg_size_m1));

  sspi_clkdiv #(.PW(PW), .RW(RW)) u_div (
    .clk(clk), .rst(rst), .run(m_busy && m_en),
    .presc(cfg_presc), .rate(cfg_rate), .tick(tick)
  );

  sspi_master #(.DW(DW), .SW(SW)) u_mst (
    .clk(clk), .rst(rst), .en(m_en), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .nb_m1(nb_m1), .loop(cfg_loop), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(m_ready), .tick(tick), .sd_in(sd_in), .sck(sck_out),
    .sel_n(sel_n_out), .dout(m_dout), .rx_data(m_rxd), .rx_valid(m_rxv),
    .busy(m_busy)
  );

  sspi_slave #(.DW(DW), .SW(SW)) u_slv (
    .clk(clk), .rst(rst), .en(s_en), .cpol(cfg_cpol), .cpha(cfg_cpha),
    .nb_m1(nb_m1), .loop(cfg_loop), .sod(cfg_sod), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(s_ready), .sck_in(sck_in),
    .sel_n_in(sel_n_in), .sd_in(sd_in), .dout(s_dout), .oe(s_oe),
    .rx_data(s_rxd), .rx_valid(s_rxv), .busy(s_busy)
  );

  assign tx_ready = cfg_master ? m_ready : s_ready;
  assign rx_data  = cfg_master ? m_rxd : s_rxd;
  assign rx_valid = cfg_master ? m_rxv : s_rxv;
  assign busy     = cfg_master ? m_busy : s_busy;
  assign sd_out   = cfg_master ? m_dout : s_dout;
  assign sd_oe    = cfg_master ? m_en : s_oe;

  // R11: a word is only taken while idle.
  p_ready_idle_r11: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> !busy)
    else $error("ready while busy");

  // R10: a disabled engine stays idle with its outputs released.
  p_disabled_r10: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (!busy && sel_n_out && !sd_oe && !tx_ready))
    else $error("activity while disabled");

endmodule

// File: tb/sspi_engine_tb_top.sv
module sspi_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SLV_HALF   = 6;

  logic        clk = 1'b0;
  logic        rst, en, cfg_master, cfg_cpol, cfg_cpha, cfg_loop, cfg_sod;
  logic [3:0]  cfg_size_m1;
  logic [7:0]  cfg_presc, cfg_rate;
  logic [15:0] tx_data, rx_data;
  logic        tx_valid, tx_ready, rx_valid, busy, sck_out, sel_n_out;
  logic        sck_in, sel_n_in, sd_in, sd_out, sd_oe;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rx_seen = 0;
  logic [15:0] rx_last = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rx_valid) begin rx_seen <= rx_seen + 1; rx_last <= rx_data; end

  sspi_engine dut_i (
    .clk(clk), .rst(rst), .en(en), .cfg_master(cfg_master), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_size_m1(cfg_size_m1), .cfg_loop(cfg_loop),
    .cfg_sod(cfg_sod), .cfg_presc(cfg_presc), .cfg_rate(cfg_rate),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .sck_out(sck_out),
    .sel_n_out(sel_n_out), .sck_in(sck_in), .sel_n_in(sel_n_in),
    .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff_bits(input int fld);
    return (fld < 3) ? 4 : fld + 1;
  endfunction

  function automatic int half_period(input int pr, input int rt);
    int h = (pr >> 1) & 127;
    if (h == 0) h = 1;
    return h * (rt + 1);
  endfunction

  function automatic logic [15:0] mask_of(input int nb);
    return 16'((32'h1 << nb) - 1);
  endfunction

  task automatic run_master(input logic [15:0] word, input logic [15:0] reply, input int fld,
                            input bit cp, input bit ph, input int pr, input int rt, input bit lb);
    int nb, t, ptr, gap, tog, guard;
    bit prev, gap_ok, sel_ok, done;
    logic [15:0] cap, msk;
    nb = eff_bits(fld); t = half_period(pr, rt); msk = mask_of(nb);
    @(negedge clk);
    en = 1; cfg_master = 1; cfg_cpol = cp; cfg_cpha = ph; cfg_size_m1 = 4'(fld);
    cfg_presc = 8'(pr); cfg_rate = 8'(rt); cfg_loop = lb; cfg_sod = 0;
    tx_data = word; tx_valid = 1;
    ptr = nb - 1;
    if (!ph) begin sd_in = reply[ptr]; ptr--; end
    guard = 0;
    while (!tx_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    tx_valid = 0;
    chk(busy && !tx_ready && !sel_n_out, "R11 busy/ready after accept", {busy, tx_ready, sel_n_out}, 3'b100);
    prev = sck_out; gap = 0; tog = 0; cap = '0; gap_ok = 1; sel_ok = 1; done = 0; guard = 0;
    while (!done && guard < 20000) begin
      @(negedge clk);
      guard++; gap++;
      if (sck_out != prev) begin
        if (tog > 0 && gap != t) gap_ok = 0;
        if (sel_n_out && !rx_valid) sel_ok = 0;
        if ((tog % 2) == int'(ph)) cap = {cap[14:0], sd_out};
        else if (ptr >= 0) begin sd_in = reply[ptr]; ptr--; end
        tog++; gap = 0; prev = sck_out;
      end
      if (rx_valid) begin
        done = 1;
        chk(rx_data == (lb ? (word & msk) : (reply & msk)), lb ? "R6 loopback word" : "R5 received word",
            32'(rx_data), 32'(lb ? (word & msk) : (reply & msk)));
        chk(!busy, "R11 busy drops with strobe", 32'(busy), 0);
      end
    end
    chk(done, "R5 strobe seen", 32'(done), 1);
    chk(tog == 2 * nb, "R2 transition count", tog, 2 * nb);
    chk(gap_ok, "R1 transition spacing", 32'(gap_ok), 1);
    chk(cap == (word & msk), "R4 bits seen on the line", 32'(cap), 32'(word & msk));
    chk(sel_ok && sel_n_out, "R8 select spans frame", {sel_ok, sel_n_out}, 2'b11);
    @(negedge clk);
    chk(sck_out == cp && !rx_valid, "R3 idle clock level and R5 single strobe", {sck_out, rx_valid}, {cp, 1'b0});
  endtask

  task automatic run_slave(input logic [15:0] word, input logic [15:0] reply, input int fld,
                           input bit cp, input bit ph, input bit sod, input bit lb);
    int nb, ptr, seen0;
    bit oe_ok;
    logic [15:0] cap, msk;
    nb = eff_bits(fld); msk = mask_of(nb);
    @(negedge clk);
    en = 1; cfg_master = 0; cfg_cpol = cp; cfg_cpha = ph; cfg_size_m1 = 4'(fld);
    cfg_loop = lb; cfg_sod = sod; sck_in = cp; sel_n_in = 1;
    tx_data = word; tx_valid = 1;
    repeat (4) @(negedge clk);
    seen0 = rx_seen;
    ptr = nb - 1;
    if (!ph) begin sd_in = reply[ptr]; ptr--; end
    sel_n_in = 0;
    repeat (SLV_HALF) @(negedge clk);
    tx_valid = 0;
    chk(busy, "R9 frame opened by select", 32'(busy), 1);
    oe_ok = (sd_oe == !sod);
    cap = '0;
    for (int k = 0; k < 2 * nb; k++) begin
      repeat (SLV_HALF) @(negedge clk);
      if ((k % 2) == int'(ph)) begin
        cap = {cap[14:0], sd_out};
        if (sd_oe != !sod) oe_ok = 0;
      end
      sck_in = ~sck_in;
      if ((k % 2) != int'(ph) && ptr >= 0) begin sd_in = reply[ptr]; ptr--; end
    end
    repeat (SLV_HALF) @(negedge clk);
    chk(oe_ok, "R7 output enable vs disable", 32'(oe_ok), 1);
    chk(rx_seen == seen0 + 1, "R9 one word per frame", rx_seen - seen0, 1);
    chk(rx_last == (lb ? (word & msk) : (reply & msk)), "R9 slave received word",
        32'(rx_last), 32'(lb ? (word & msk) : (reply & msk)));
    if (!sod) chk(cap == (word & msk), "R9 slave sent word", 32'(cap), 32'(word & msk));
    sel_n_in = 1;
    repeat (4) @(negedge clk);
    chk(!busy && !sd_oe, "R7 released after deselect", {busy, sd_oe}, 2'b00);
  endtask

  initial begin
    wait (cyc >= 150000);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    rst = 1; en = 0; cfg_master = 1; cfg_cpol = 0; cfg_cpha = 0; cfg_loop = 0; cfg_sod = 0;
    cfg_size_m1 = 4'd7; cfg_presc = 8'd2; cfg_rate = 8'd0; tx_data = '0; tx_valid = 0;
    sck_in = 0; sel_n_in = 1; sd_in = 0;
    repeat (4) @(negedge clk);
    chk(!busy && sel_n_out && !sd_oe && !rx_valid && !tx_ready && !sck_out,
        "R10 reset state", {busy, sel_n_out, sd_oe, rx_valid, tx_ready, sck_out}, 6'b010000);
    rst = 0;

    // R10: disabled engine ignores an offered word
    tx_valid = 1; tx_data = 16'h1234;
    begin
      bit quiet = 1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (tx_ready || busy || !sel_n_out || sd_oe) quiet = 0;
      end
      chk(quiet, "R10 no activity while disabled", 32'(quiet), 1);
    end
    tx_valid = 0;

    run_master(16'h00A5, 16'h003C, 7, 0, 0, 2, 0, 0);
    run_master(16'hBEEF, 16'h4D2C, 15, 1, 1, 4, 1, 0);
    run_master(16'h005A, 16'h00C3, 7, 0, 1, 6, 0, 0);
    run_master(16'h0F96, 16'h0669, 11, 1, 0, 2, 2, 0);
    run_master(16'hFFFB, 16'hFFF4, 1, 0, 0, 2, 0, 0);    // R2 clamp to 4 bits
    run_master(16'h0133, 16'h02CC, 9, 0, 0, 5, 2, 0);    // R1 odd prescale
    run_master(16'h0071, 16'h008E, 7, 1, 1, 0, 3, 0);    // R1 prescale floor
    run_master(16'h6C3A, 16'h93C5, 15, 0, 1, 2, 1, 1);   // R6 loopback

    for (int n = 0; n < 20; n++) begin
      run_master(16'($urandom), 16'($urandom), int'($urandom_range(0, 15)),
                 1'($urandom), 1'($urandom), int'($urandom_range(0, 7)),
                 int'($urandom_range(0, 3)), 1'($urandom_range(0, 3) == 0));
    end

    // R10: dropping enable mid frame returns to idle
    @(negedge clk);
    cfg_master = 1; en = 1; cfg_presc = 8'd4; cfg_rate = 8'd3; cfg_size_m1 = 4'd15;
    cfg_cpol = 1; tx_data = 16'hAAAA; tx_valid = 1;
    @(negedge clk);
    tx_valid = 0;
    repeat (10) @(negedge clk);
    chk(busy, "R11 frame in progress", 32'(busy), 1);
    en = 0;
    repeat (2) @(negedge clk);
    chk(!busy && sel_n_out && !sd_oe && sck_out == 1'b1, "R10 abort to idle",
        {busy, sel_n_out, sd_oe, sck_out}, 4'b0101);

    run_slave(16'h00C9, 16'h0036, 7, 0, 0, 0, 0);
    run_slave(16'h0ABC, 16'h0543, 11, 1, 1, 0, 0);
    run_slave(16'h00E1, 16'h001E, 7, 0, 1, 1, 0);         // R7 output disabled
    run_slave(16'h3C5A, 16'h0000, 15, 1, 0, 0, 1);        // R6 loopback in following role
    for (int n = 0; n < 4; n++) begin
      run_slave(16'($urandom), 16'($urandom), int'($urandom_range(3, 15)),
                1'($urandom), 1'($urandom), 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule